// File: doc/BRIEF.md
# Clock Tolerance Compensation FIFO

This block carries 10-bit code groups from the recovered receive clock into the local reference clock through a small dual-clock elastic buffer. The two clocks run at nominally the same rate but drift apart by a small amount. The block absorbs that difference without harming frame content. When the buffer fills past an upper mark, the write side throws away one complete idle ordered set. When the buffer drains below a lower mark, the read side plays the most recent idle ordered set a second time. An idle ordered set is a comma code group followed by one non-comma code group. Idles only appear between packets, so packet code groups are never added or removed.

Pointers cross between the clock domains in Gray code through two-flop synchronisers. After reset the reader waits for the buffer to reach a priming level before it produces output. From then on it delivers one code group per reference clock. A select input turns compensation off, and the block then acts as a plain dual-clock FIFO. Sticky flags record a pointer collision on either side until the next reset.

Top module: `ctc_fifo`

## Requirements
- R1: While reset is held, `rd_valid`, `unf_flag`, `ovf_flag`, `del_pulse` and `ins_pulse` are 0 and `rd_data` is all zeros.
- R2: With compensation on, every packet code group (any value that is neither a comma nor part of an idle set) leaves in the order it entered, none lost and none repeated.
- R3: With `comp_en` low, the output stream is exactly the input stream: the first valid output equals the first code group written after reset, and neither `del_pulse` nor `ins_pulse` ever pulses.
- R4: With compensation on and a write clock faster than the read clock, the block removes idle sets and pulses `del_pulse` once for each removed set. A comma is 10'b0011111010 or 10'b1100000101 on `wr_data[9:0]`.
- R5: With compensation on and a write clock slower than the read clock, the block adds idle sets and pulses `ins_pulse` once for each added set.
- R6: Compensation works on whole sets. In the output stream each comma is followed directly by its non-comma partner, and no partner appears without its comma.
- R7: A stream with no idle sets is never subject to deletion, even when the buffer is above the upper mark.
- R8: A write into a full buffer sets `ovf_flag`, which stays set until reset.
- R9: A read from an empty buffer after output has started sets `unf_flag`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered clock; one code group per rising edge |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_data | input | 10 | Incoming code group |
| rd_clk | input | 1 | Local reference clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| comp_en | input | 1 | 1 turns on idle insertion and deletion; 0 bypasses compensation |
| rd_data | output | 10 | Outgoing code group, registered in the read domain |
| rd_valid | output | 1 | High once the read stream has started |
| ovf_flag | output | 1 | Sticky overflow, write domain |
| unf_flag | output | 1 | Sticky underflow, read domain |
| del_pulse | output | 1 | One write-clock pulse for each deleted idle set |
| ins_pulse | output | 1 | One read-clock pulse for each inserted idle set |

## Verification
The hardest condition to reach from the ports is a sustained fill level beyond a threshold. Inserts, deletes and both collisions only happen after many cycles of accumulated drift between two free-running clocks. The bench therefore runs the write clock 2.5 percent faster or slower than the 250 MHz reference for thousands of cycles. It uses a stream of numbered packets separated by idle sets, so that order and set integrity can be checked on the output. A variant with no gaps at all drives the buffer full while giving the block nothing it is allowed to delete. The bypass variants let the pointers collide in both directions.

// File: rtl/ctc_pkg.sv
package ctc_pkg;
  localparam int CG_W = 10;
  localparam logic [CG_W-1:0] COMMA_NEG = 10'b0011111010;
  localparam logic [CG_W-1:0] COMMA_POS = 10'b1100000101;

  typedef enum logic {RD_NORM, RD_REPEAT} rd_state_t;

  function automatic logic is_comma(input logic [CG_W-1:0] cg);
    return (cg == COMMA_NEG) || (cg == COMMA_POS);
  endfunction
endpackage

// File: rtl/ctc_sync.sv
module ctc_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/ctc_ram.sv
module ctc_ram #(
  parameter int W  = 10,
  parameter int AW = 5
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          rclk,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ctc_wr_side.sv
module ctc_wr_side #(
  parameter int AW   = 5,
  parameter int HIGH = 22
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ctc_pkg::CG_W-1:0] din,
  input  logic                     comp_en,
  input  logic [AW:0]              rd_gray_s,
  output logic                     we,
  output logic [AW-1:0]            waddr,
  output logic [ctc_pkg::CG_W-1:0] wdata,
  output logic [AW:0]              wr_gray,
  output logic                     ovf,
  output logic                     del_pulse
);
  import ctc_pkg::*;
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [CG_W-1:0] prev;
  logic            prev_v, skip_next;
  logic [AW:0]     wptr, wptr_inc, rd_bin, fill;
  logic            full, set_start, drop, want;

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    for (int i = 0; i <= AW; i++) b[i] = ^(g >> i);
    return b;
  endfunction

  always_comb begin
    rd_bin    = g2b(rd_gray_s);
    fill      = wptr - rd_bin;
    full      = (fill == PW'(DEPTH));
    wptr_inc  = wptr + 1'b1;
    set_start = prev_v && !skip_next && is_comma(prev) && !is_comma(din);
    drop      = comp_en && set_start && (fill > PW'(HIGH));
    want      = prev_v && !skip_next && !drop;
    we        = want && !full;
    waddr     = wptr[AW-1:0];
    wdata     = prev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev      <= '0;
      prev_v    <= 1'b0;
      skip_next <= 1'b0;
      wptr      <= '0;
      wr_gray   <= '0;
      ovf       <= 1'b0;
      del_pulse <= 1'b0;
    end else begin
      prev      <= din;
      prev_v    <= 1'b1;
      skip_next <= drop;
      del_pulse <= drop;
      if (want) begin
        if (full) begin
          ovf <= 1'b1;
        end else begin
          wptr    <= wptr_inc;
          wr_gray <= wptr_inc ^ (wptr_inc >> 1);
        end
      end
    end
  end

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);

  a_r6_del_spacing: assert property (@(posedge clk) disable iff (rst)
    del_pulse |=> !del_pulse);

  a_r4_del_whole_set: assert property (@(posedge clk) disable iff (rst)
    del_pulse |-> (is_comma($past(prev)) && !is_comma(prev) && (wptr == $past(wptr))));
endmodule

// File: rtl/ctc_rd_side.sv
module ctc_rd_side #(
  parameter int AW    = 5,
  parameter int LOW   = 10,
  parameter int PRIME = 13
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     comp_en,
  input  logic [AW:0]              wr_gray_s,
  input  logic [ctc_pkg::CG_W-1:0] rdata,
  output logic [AW-1:0]            raddr,
  output logic [AW:0]              rd_gray,
  output logic [ctc_pkg::CG_W-1:0] dout,
  output logic                     dout_v,
  output logic                     unf,
  output logic                     ins_pulse
);
  import ctc_pkg::*;
  localparam int PW = AW + 1;

  rd_state_t       state;
  logic [CG_W-1:0] dout_q1;
  logic [AW:0]     rptr, rptr_inc, wr_bin, fill;
  logic            primed, empty, ins, advance;

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    for (int i = 0; i <= AW; i++) b[i] = ^(g >> i);
    return b;
  endfunction

  always_comb begin
    wr_bin   = g2b(wr_gray_s);
    fill     = wr_bin - rptr;
    empty    = (fill == '0);
    rptr_inc = rptr + 1'b1;
    ins      = comp_en && primed && (state == RD_NORM) && dout_v &&
               is_comma(dout_q1) && !is_comma(dout) && (fill < PW'(LOW));
    advance  = primed && (state == RD_NORM) && !ins && !empty;
    raddr    = advance ? rptr_inc[AW-1:0] : rptr[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RD_NORM;
      dout      <= '0;
      dout_q1   <= '0;
      dout_v    <= 1'b0;
      rptr      <= '0;
      rd_gray   <= '0;
      primed    <= 1'b0;
      unf       <= 1'b0;
      ins_pulse <= 1'b0;
    end else begin
      ins_pulse <= ins;
      if (!primed) begin
        primed <= (fill >= PW'(PRIME));
      end else if (state == RD_REPEAT) begin
        dout    <= dout_q1;
        dout_q1 <= dout;
        state   <= RD_NORM;
      end else if (ins) begin
        dout    <= dout_q1;
        dout_q1 <= dout;
        state   <= RD_REPEAT;
      end else if (!empty) begin
        dout    <= rdata;
        dout_q1 <= dout;
        dout_v  <= 1'b1;
        rptr    <= rptr_inc;
        rd_gray <= rptr_inc ^ (rptr_inc >> 1);
      end else begin
        unf <= 1'b1;
      end
    end
  end

  a_r9_unf_sticky: assert property (@(posedge clk) disable iff (rst)
    unf |=> unf);

  a_r5_ins_comma_first: assert property (@(posedge clk) disable iff (rst)
    ins_pulse |-> is_comma(dout));

  a_r6_ins_tail: assert property (@(posedge clk) disable iff (rst)
    ins_pulse |=> !is_comma(dout));

  a_r2_rptr_step: assert property (@(posedge clk) disable iff (rst)
    (rptr == $past(rptr)) || (rptr == $past(rptr) + 1'b1));
endmodule

// File: rtl/ctc_fifo.sv
module ctc_fifo #(
  parameter int AW     = 5,
  parameter int MARGIN = 6,
  parameter int LAG    = 3
) (
  input  logic                     wr_clk,
  input  logic                     wr_rst,
  input  logic [ctc_pkg::CG_W-1:0] wr_data,
  input  logic                     rd_clk,
  input  logic                     rd_rst,
  input  logic                     comp_en,
  output logic [ctc_pkg::CG_W-1:0] rd_data,
  output logic                     rd_valid,
  output logic                     ovf_flag,
  output logic                     unf_flag,
  output logic                     del_pulse,
  output logic                     ins_pulse
);
  import ctc_pkg::*;
  localparam int DEPTH = 1 << AW;
  localparam int HIGH  = DEPTH / 2 + MARGIN;
  localparam int LOW   = DEPTH / 2 - MARGIN;
  localparam int PRIME = DEPTH / 2 - LAG;

  logic            en_w, en_r, we;
  logic [AW-1:0]   waddr, raddr;
  logic [CG_W-1:0] wdata, rdata;
  logic [AW:0]     wr_gray, rd_gray, wr_gray_s, rd_gray_s;

  ctc_sync #(.W(1)) i_en_w (.clk(wr_clk), .rst(wr_rst), .d(comp_en), .q(en_w));
  ctc_sync #(.W(1)) i_en_r (.clk(rd_clk), .rst(rd_rst), .d(comp_en), .q(en_r));
  ctc_sync #(.W(AW+1)) i_rp_sync (.clk(wr_clk), .rst(wr_rst), .d(rd_gray), .q(rd_gray_s));
  ctc_sync #(.W(AW+1)) i_wp_sync (.clk(rd_clk), .rst(rd_rst), .d(wr_gray), .q(wr_gray_s));

  ctc_wr_side #(.AW(AW), .HIGH(HIGH)) i_wr (
    .clk(wr_clk), .rst(wr_rst), .din(wr_data), .comp_en(en_w),
    .rd_gray_s(rd_gray_s), .we(we), .waddr(waddr), .wdata(wdata),
    .wr_gray(wr_gray), .ovf(ovf_flag), .del_pulse(del_pulse)
  );

  ctc_ram #(.W(CG_W), .AW(AW)) i_ram (
    .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wdata),
    .rclk(rd_clk), .raddr(raddr), .rdata(rdata)
  );

  ctc_rd_side #(.AW(AW), .LOW(LOW), .PRIME(PRIME)) i_rd (
    .clk(rd_clk), .rst(rd_rst), .comp_en(en_r), .wr_gray_s(wr_gray_s),
    .rdata(rdata), .raddr(raddr), .rd_gray(rd_gray), .dout(rd_data),
    .dout_v(rd_valid), .unf(unf_flag), .ins_pulse(ins_pulse)
  );
endmodule

// File: tb/test_ctc_fifo.sv
`timescale 1ns/1ps
module test_ctc_fifo;
  localparam int PKT = 20;
  localparam logic [9:0] IDLE_TAIL = 10'h2A5;

  logic       wr_clk = 1'b0, rd_clk = 1'b0;
  logic       wr_rst = 1'b1, rd_rst = 1'b1, comp_en = 1'b0;
  logic [9:0] wr_data = '0;
  logic [9:0] rd_data;
  logic       rd_valid, ovf_flag, unf_flag, del_pulse, ins_pulse;

  real wr_half = 2.0;
  int  checks = 0, errors = 0;
  int  gap_cur = 6, idx = 0;
  bit  gen_on = 0, mon_on = 0, exact = 0;
  int  n_del, n_ins, n_words, mism, seq_err, pair_err, exp_seq;
  bit  want_tail;

  ctc_fifo i_ctc_fifo (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_data(wr_data),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .comp_en(comp_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .ovf_flag(ovf_flag),
    .unf_flag(unf_flag), .del_pulse(del_pulse), .ins_pulse(ins_pulse)
  );

  initial forever #2.0 rd_clk = ~rd_clk;
  initial forever #(wr_half) wr_clk = ~wr_clk;

  function automatic logic [9:0] gen_cg(input int k, input int gap);
    int per, pos, seq;
    per = PKT + 2 * gap;
    pos = k % per;
    if (pos < 2 * gap) begin
      if (pos % 2 == 1) return IDLE_TAIL;
      return ((pos / 2) % 2 == 1) ? ctc_pkg::COMMA_POS : ctc_pkg::COMMA_NEG;
    end
    seq = (k / per) * PKT + (pos - 2 * gap);
    return {2'b01, 8'(seq)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // write-side stimulus and deletion counting
  initial forever begin
    @(negedge wr_clk);
    if (gen_on) begin
      if (del_pulse) n_del++;
      wr_data = gen_cg(idx, gap_cur);
      idx++;
    end
  end

  // read-side monitor
  initial forever begin
    @(negedge rd_clk);
    if (mon_on) begin
      if (ins_pulse) n_ins++;
      if (rd_valid) begin
        if (exact) begin
          if (rd_data != gen_cg(n_words, gap_cur)) mism++;
        end else if (ctc_pkg::is_comma(rd_data)) begin
          if (want_tail) pair_err++;
          want_tail = 1;
        end else if (rd_data == IDLE_TAIL) begin
          if (!want_tail) pair_err++;
          want_tail = 0;
        end else begin
          if (want_tail) pair_err++;
          want_tail = 0;
          if (rd_data != {2'b01, 8'(exp_seq)}) seq_err++;
          exp_seq++;
        end
        n_words++;
      end
    end
  end

  task automatic run(input bit en, input real whalf, input int gap,
                     input int ncyc, input bit ex);
    gen_on = 0; mon_on = 0;
    wr_rst = 1; rd_rst = 1;
    comp_en = en; wr_half = whalf; gap_cur = gap; exact = ex;
    idx = 0; wr_data = gen_cg(0, gap);
    n_del = 0; n_ins = 0; n_words = 0; mism = 0; seq_err = 0; pair_err = 0;
    exp_seq = 0; want_tail = 0;
    repeat (6) @(posedge wr_clk);
    repeat (6) @(posedge rd_clk);
    @(negedge rd_clk);
    chk(rd_valid == 0 && unf_flag == 0 && ins_pulse == 0, "R1", "rd flags in reset",
        {rd_valid, unf_flag, ins_pulse}, 0);
    chk(rd_data == 0, "R1", "rd_data in reset", rd_data, 0);
    @(negedge wr_clk);
    chk(ovf_flag == 0 && del_pulse == 0, "R1", "wr flags in reset",
        {ovf_flag, del_pulse}, 0);
    @(posedge wr_clk); #0.5;
    wr_rst = 0; gen_on = 1;
    @(posedge rd_clk); #0.5;
    rd_rst = 0; mon_on = 1;
    repeat (ncyc) @(posedge rd_clk);
    @(negedge rd_clk);
    mon_on = 0;
    @(negedge wr_clk);
    gen_on = 0;
  endtask

  task automatic t_bypass_equal;
    run(0, 2.0, 6, 3000, 1);
    chk(mism == 0, "R3", "bypass stream mismatches", mism, 0);
    chk(n_words > 2500, "R3", "bypass words delivered", n_words, 2500);
    chk(n_del == 0 && n_ins == 0, "R3", "bypass ins+del pulses", n_del + n_ins, 0);
  endtask

  task automatic t_fast_writer;
    run(1, 1.95, 6, 4000, 0);
    chk(seq_err == 0, "R2", "packet order errors, fast writer", seq_err, 0);
    chk(exp_seq > 2000, "R2", "packet words seen, fast writer", exp_seq, 2000);
    chk(pair_err == 0, "R6", "idle pairing errors, fast writer", pair_err, 0);
    chk(n_del > 0, "R4", "deletions, fast writer", n_del, 1);
    chk(ovf_flag == 0, "R8", "overflow with compensation", ovf_flag, 0);
  endtask

  task automatic t_slow_writer;
    run(1, 2.05, 6, 4000, 0);
    chk(seq_err == 0, "R2", "packet order errors, slow writer", seq_err, 0);
    chk(pair_err == 0, "R6", "idle pairing errors, slow writer", pair_err, 0);
    chk(n_ins > 0, "R5", "insertions, slow writer", n_ins, 1);
    chk(unf_flag == 0, "R9", "underflow with compensation", unf_flag, 0);
  endtask

  task automatic t_no_gap;
    run(1, 1.95, 0, 3000, 0);
    chk(n_del == 0, "R7", "deletions without idles", n_del, 0);
    chk(ovf_flag == 1, "R8", "overflow without idles", ovf_flag, 1);
  endtask

  task automatic t_bypass_slow;
    run(0, 2.05, 6, 3000, 0);
    chk(unf_flag == 1, "R9", "underflow in bypass", unf_flag, 1);
    chk(n_ins == 0, "R3", "insertions in bypass", n_ins, 0);
  endtask

  task automatic t_bypass_fast;
    run(0, 1.95, 6, 3000, 0);
    chk(ovf_flag == 1, "R8", "overflow in bypass", ovf_flag, 1);
    chk(n_del == 0, "R3", "deletions in bypass", n_del, 0);
  endtask

  initial begin
    #600000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_bypass_equal();
    t_fast_writer();
    t_slow_writer();
    t_no_gap();
    t_bypass_slow();
    t_bypass_fast();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule